// File: doc/BRIEF.md
# Line-Doubling Bob Deinterlacer

This block converts an interlaced pixel stream into progressive frames. Only fields of even parity (parity 0) are kept. Each kept field is doubled vertically, so a field of `FIELD_LINES` lines becomes a frame of twice that many lines. Fields of odd parity are consumed and produce no output. Both sides use a valid/ready handshake. Pixels carry `NCOMP` colour components of `COMP_W` bits each, with component 0 in the least significant bits.

A mode bit picks the way each missing line is made. Duplicate mode sends every field line twice. Interpolate mode sends field line k unchanged as output line 2k. Output line 2k+1 is then the rounded mean of lines k and k+1, worked out per component. The bottom field line has no neighbour below, so it is sent twice. A single line store of `LINE_W` entries holds the previous field line and the pending interpolated line. The input stalls while the block replays a stored line. Downstream may stall the output on any cycle.

Top module: `bob_deint_top`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: A field whose first pixel has in_field = 1 is accepted in full and adds no output pixel.
- R3: In duplicate mode (mode_interp = 0 at the field start), output lines 2k and 2k+1 both equal field line k, pixel for pixel.
- R4: In interpolate mode (mode_interp = 1 at the field start), output line 2k equals field line k. For k below the last line, output line 2k+1 is, per COMP_W-bit component, (a + b + 1) >> 1 of the co-located pixels of lines k and k+1.
- R5: In interpolate mode, the output line after the bottom field line is a copy of that bottom line.
- R6: Each kept field yields exactly 2*FIELD_LINES output lines of LINE_W pixels, in order.
- R7: in_ready is 0 while a stored line is being replayed, and whenever the output register is full and stalled. With no output stall, a duplicate-mode field fed back to back is refused for LINE_W*(FIELD_LINES-1) cycles.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_data, out_sof and out_eol hold their values.
- R9: out_sof is 1 only on the first pixel of each progressive frame. out_eol is 1 on the last pixel of every output line and on no other pixel.
- R10: mode_interp is read only on the pixel that has in_sof = 1. Changing it later in the field has no effect.
- R11: The mean cannot overflow: 0xFF with 0xFF gives 0xFF, and 0xFF with 0x00 gives 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_data | input | NCOMP*COMP_W | Input pixel, component 0 in the low bits |
| in_sof | input | 1 | First pixel of a field |
| in_sol | input | 1 | First pixel of a line |
| in_field | input | 1 | Field parity, read with in_sof |
| mode_interp | input | 1 | 0 duplicate, 1 interpolate, read with in_sof |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_data | output | NCOMP*COMP_W | Output pixel |
| out_sof | output | 1 | First pixel of a progressive frame |
| out_eol | output | 1 | Last pixel of an output line |

## Verification
The hardest situation to reach is a combined one: the tail of an interpolated field, where two copies of the bottom line follow the last mean line, has to coincide with output stalls and with the next field already waiting at the input. The stimulus feeds fields back to back, with random parity and mode and with out_ready dropped at random. Tails therefore overlap stalls and parity changes. Directed fields add the overflow values, a mode change in the middle of a field, and a stall-free run in which the input refusals are counted.

// File: rtl/bob_pkg.sv
package bob_pkg;
  typedef enum logic [2:0] {
    ST_IN     = 3'd0,
    ST_COPY   = 3'd1,
    ST_MID    = 3'd2,
    ST_TAIL_A = 3'd3,
    ST_TAIL_B = 3'd4
  } bob_state_e;
endpackage

// File: rtl/bob_pix_avg.sv
module bob_pix_avg #(
  parameter int COMP_W = 8,
  parameter int NCOMP  = 3,
  localparam int PIX_W = COMP_W * NCOMP
) (
  input  logic [PIX_W-1:0] a,
  input  logic [PIX_W-1:0] b,
  output logic [PIX_W-1:0] y
);
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    logic [COMP_W:0] sum;
    always_comb begin
      sum = {1'b0, a[c*COMP_W +: COMP_W]} + {1'b0, b[c*COMP_W +: COMP_W]} + (COMP_W+1)'(1);
      y[c*COMP_W +: COMP_W] = sum[COMP_W:1];
    end
  end
endmodule

// File: rtl/bob_line_store.sv
module bob_line_store #(
  parameter int PIX_W  = 24,
  parameter int LINE_W = 64,
  localparam int AW    = $clog2(LINE_W)
) (
  input  logic             clk,
  input  logic             we_cur,
  input  logic             we_mid,
  input  logic [AW-1:0]    wr_addr,
  input  logic [PIX_W-1:0] cur_wdata,
  input  logic [PIX_W-1:0] mid_wdata,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] cur_rdata,
  output logic [PIX_W-1:0] mid_rdata
);
  logic [PIX_W-1:0] cur_mem [LINE_W];
  logic [PIX_W-1:0] mid_mem [LINE_W];

  always_ff @(posedge clk) begin
    if (we_cur) cur_mem[wr_addr] <= cur_wdata;
    if (we_mid) mid_mem[wr_addr] <= mid_wdata;
  end

  assign cur_rdata = cur_mem[rd_addr];
  assign mid_rdata = mid_mem[rd_addr];
endmodule

// File: rtl/bob_out_stage.sv
module bob_out_stage #(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PIX_W-1:0] d_data,
  input  logic             d_sof,
  input  logic             d_eol,
  input  logic             o_ready,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_data,
  output logic             o_sof,
  output logic             o_eol
);
  logic valid_nxt;

  always_comb begin
    valid_nxt = o_valid;
    if (load)         valid_nxt = 1'b1;
    else if (o_ready) valid_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_valid <= 1'b0;
    else        o_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_sof <= 1'b0;
      o_eol <= 1'b0;
    end else if (load) begin
      o_sof <= d_sof;
      o_eol <= d_eol;
    end
  end

  always_ff @(posedge clk) begin
    if (load) o_data <= d_data;
  end
endmodule

// File: rtl/bob_deint_top.sv
module bob_deint_top
  import bob_pkg::*;
#(
  parameter int LINE_W      = 64,
  parameter int FIELD_LINES = 16,
  parameter int COMP_W      = 8,
  parameter int NCOMP       = 3,
  localparam int PIX_W      = COMP_W * NCOMP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_sol,
  input  logic             in_field,
  input  logic             mode_interp,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol
);
  localparam int CW  = $clog2(LINE_W);
  localparam int LNW = $clog2(FIELD_LINES + 1);
  localparam logic [CW-1:0]  COL_LAST  = CW'(LINE_W - 1);
  localparam logic [LNW-1:0] LINE_LAST = LNW'(FIELD_LINES - 1);

  bob_state_e       state_q, state_nxt;
  logic [CW-1:0]    col_q, col_nxt, eff_col, rd_addr;
  logic [LNW-1:0]   line_q, line_nxt, eff_line;
  logic             par_q, par_nxt, mode_q, mode_nxt;
  logic             last_q, last_nxt, pend_q, pend_nxt;
  logic             eff_par, eff_mode, keep, has_prev, last_col, last_line;
  logic             slot_free, acc, emit, emit_sof, emit_eol;
  logic [PIX_W-1:0] emit_data, cur_rdata, mid_rdata, avg_data;
  logic             we_cur, we_mid;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (state_q == ST_IN) && slot_free;
  assign acc       = in_valid && in_ready;

  assign eff_col   = in_sol ? '0 : col_q;
  assign eff_line  = in_sof ? '0 : line_q;
  assign eff_par   = in_sof ? in_field : par_q;
  assign eff_mode  = in_sof ? mode_interp : mode_q;
  assign keep      = !eff_par;
  assign has_prev  = (eff_line != '0);
  assign last_col  = (eff_col == COL_LAST);
  assign last_line = (eff_line == LINE_LAST);
  assign rd_addr   = (state_q == ST_IN) ? eff_col : col_q;

  assign we_cur = acc && keep;
  assign we_mid = acc && keep && eff_mode && has_prev;

  bob_line_store #(.PIX_W(PIX_W), .LINE_W(LINE_W)) u_store (
    .clk       (clk),
    .we_cur    (we_cur),
    .we_mid    (we_mid),
    .wr_addr   (eff_col),
    .cur_wdata (in_data),
    .mid_wdata (avg_data),
    .rd_addr   (rd_addr),
    .cur_rdata (cur_rdata),
    .mid_rdata (mid_rdata)
  );

  bob_pix_avg #(.COMP_W(COMP_W), .NCOMP(NCOMP)) u_avg (
    .a (cur_rdata),
    .b (in_data),
    .y (avg_data)
  );

  // Output selection for the current cycle.
  always_comb begin
    if (state_q == ST_IN) begin
      emit      = acc && keep && (!eff_mode || has_prev);
      emit_data = eff_mode ? cur_rdata : in_data;
      emit_eol  = last_col;
    end else begin
      emit      = slot_free;
      emit_data = (state_q == ST_MID) ? mid_rdata : cur_rdata;
      emit_eol  = (col_q == COL_LAST);
    end
    emit_sof = emit && (pend_q || (acc && in_sof && !in_field));
  end

  // Next-state logic.
  always_comb begin
    state_nxt = state_q;
    col_nxt   = col_q;
    line_nxt  = line_q;
    par_nxt   = par_q;
    mode_nxt  = mode_q;
    last_nxt  = last_q;
    pend_nxt  = pend_q;

    if (emit)                              pend_nxt = 1'b0;
    else if (acc && in_sof && !in_field)   pend_nxt = 1'b1;

    if (acc && in_sof) begin
      par_nxt  = in_field;
      mode_nxt = mode_interp;
    end

    unique case (state_q)
      ST_IN: begin
        if (acc) begin
          col_nxt  = last_col ? '0 : eff_col + CW'(1);
          line_nxt = last_col ? eff_line + LNW'(1) : eff_line;
          if (keep && last_col) begin
            last_nxt = last_line;
            if (!eff_mode)      state_nxt = ST_COPY;
            else if (has_prev)  state_nxt = ST_MID;
            else if (last_line) state_nxt = ST_TAIL_A;
          end
        end
      end
      default: begin
        if (slot_free) begin
          col_nxt = (col_q == COL_LAST) ? '0 : col_q + CW'(1);
          if (col_q == COL_LAST) begin
            unique case (state_q)
              ST_MID:    state_nxt = last_q ? ST_TAIL_A : ST_IN;
              ST_TAIL_A: state_nxt = ST_TAIL_B;
              default:   state_nxt = ST_IN;
            endcase
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IN;
      col_q   <= '0;
      line_q  <= '0;
      par_q   <= 1'b0;
      mode_q  <= 1'b0;
      last_q  <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      col_q   <= col_nxt;
      line_q  <= line_nxt;
      par_q   <= par_nxt;
      mode_q  <= mode_nxt;
      last_q  <= last_nxt;
      pend_q  <= pend_nxt;
    end
  end

  bob_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (emit),
    .d_data  (emit_data),
    .d_sof   (emit_sof),
    .d_eol   (emit_eol),
    .o_ready (out_ready),
    .o_valid (out_valid),
    .o_data  (out_data),
    .o_sof   (out_sof),
    .o_eol   (out_eol)
  );
endmodule

// File: rtl/bob_deint_checker.sv
module bob_deint_checker #(
  parameter int LINE_W = 64,
  parameter int PIX_W  = 24,
  localparam int CW    = $clog2(LINE_W)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_data,
  input logic             out_sof,
  input logic             out_eol
);
  logic [CW-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else if (out_valid && out_ready)
      beat_q <= (beat_q == CW'(LINE_W - 1)) ? '0 : beat_q + CW'(1);
  end

  a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_eol));

  a_r9_eol_period: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |-> out_eol == (beat_q == CW'(LINE_W - 1)));

  a_r9_sof_line_start: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> beat_q == '0);

  a_r7_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid || out_ready));
endmodule

bind bob_deint_top bob_deint_checker #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_eol   (out_eol)
);

// File: tb/bob_deint_top_test.sv
module bob_deint_top_test;
  localparam int LW = 8;
  localparam int FL = 4;
  localparam int CWB = 8;
  localparam int NC = 3;
  localparam int PW = CWB * NC;
  localparam int EXPN = 4096;

  logic clk, rst_n;
  logic in_valid, in_ready, in_sof, in_sol, in_field, mode_interp;
  logic [PW-1:0] in_data, out_data;
  logic out_valid, out_ready, out_sof, out_eol;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int blocked = 0;
  bit bp_on   = 0;

  logic [PW-1:0] fld [FL][LW];
  logic [PW-1:0] exp_pix [EXPN];
  bit            exp_sof [EXPN];
  bit            exp_eol [EXPN];
  int exp_wr = 0;
  int exp_rd = 0;

  bob_deint_top #(.LINE_W(LW), .FIELD_LINES(FL), .COMP_W(CWB), .NCOMP(NC)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sof(in_sof), .in_sol(in_sol), .in_field(in_field),
    .mode_interp(mode_interp), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_sof(out_sof), .out_eol(out_eol)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [PW-1:0] mean_px(input logic [PW-1:0] a, input logic [PW-1:0] b);
    logic [PW-1:0] r;
    for (int c = 0; c < NC; c++) begin
      int s;
      s = (int'(a[c*CWB +: CWB]) + int'(b[c*CWB +: CWB]) + 1) >> 1;
      r[c*CWB +: CWB] = CWB'(s);
    end
    return r;
  endfunction

  task automatic push_exp(input logic [PW-1:0] p, input bit s, input bit e);
    exp_pix[exp_wr] = p;
    exp_sof[exp_wr] = s;
    exp_eol[exp_wr] = e;
    exp_wr++;
  endtask

  // Expected frame from the field contents: R3, R4, R5, R9.
  task automatic build_exp(input bit interp);
    bit first;
    first = 1;
    for (int k = 0; k < FL; k++) begin
      for (int c = 0; c < LW; c++) begin
        push_exp(fld[k][c], first, c == LW - 1);
        first = 0;
      end
      for (int c = 0; c < LW; c++) begin
        if (interp && k < FL - 1) push_exp(mean_px(fld[k][c], fld[k+1][c]), 0, c == LW - 1);
        else                      push_exp(fld[k][c], 0, c == LW - 1);
      end
    end
  endtask

  task automatic fill_random();
    for (int k = 0; k < FL; k++)
      for (int c = 0; c < LW; c++) fld[k][c] = PW'($urandom);
  endtask

  task automatic send_field(input bit par, input bit mode_sof, input bit mode_rest);
    for (int k = 0; k < FL; k++) begin
      for (int c = 0; c < LW; c++) begin
        @(negedge clk);
        in_valid    = 1;
        in_data     = fld[k][c];
        in_sof      = (k == 0 && c == 0);
        in_sol      = (c == 0);
        in_field    = par;
        mode_interp = (k == 0 && c == 0) ? mode_sof : mode_rest;
        #2;
        while (!in_ready) begin
          @(negedge clk);
          #2;
        end
      end
    end
    @(negedge clk);
    in_valid = 0;
    in_sof   = 0;
    in_sol   = 0;
  endtask

  task automatic drain(input string req);
    int t;
    t = 0;
    while (exp_rd != exp_wr && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (10) @(negedge clk);
    chk(exp_rd == exp_wr, req, 64'(exp_rd), 64'(exp_wr));
  endtask

  // Output monitor, sampled away from the active edge.
  always @(negedge clk) begin
    if (rst_n) out_ready <= bp_on ? ($urandom_range(0, 3) != 0) : 1'b1;
    #2;
    if (rst_n && in_valid && !in_ready) blocked++;
    if (rst_n && out_valid && out_ready) begin
      if (exp_rd >= exp_wr) begin
        chk(0, "R2/R6 unexpected output", 64'(out_data), 64'(0));
      end else begin
        chk(out_data == exp_pix[exp_rd], "R3/R4/R5 pixel", 64'(out_data), 64'(exp_pix[exp_rd]));
        chk(out_sof == exp_sof[exp_rd] && out_eol == exp_eol[exp_rd], "R9 markers",
            64'({out_sof, out_eol}), 64'({exp_sof[exp_rd], exp_eol[exp_rd]}));
        exp_rd++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", 64'(cyc), 64'(150000));
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; in_data = '0; in_sof = 0; in_sol = 0;
    in_field = 0; mode_interp = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 64'(0));
    chk(in_ready == 1, "R1 in_ready", 64'(in_ready), 64'(1));

    // R7: stall-free duplicate field, count refused cycles.
    fill_random();
    build_exp(0);
    blocked = 0;
    send_field(0, 0, 0);
    chk(blocked == LW * (FL - 1), "R7 refused cycles", 64'(blocked), 64'(LW * (FL - 1)));
    drain("R3/R6 duplicate field");

    // R2: odd field produces nothing.
    fill_random();
    send_field(1, 1, 1);
    drain("R2 odd field silent");

    // R4/R5: interpolated field with stalls.
    bp_on = 1;
    fill_random();
    build_exp(1);
    send_field(0, 1, 1);
    drain("R4/R5 interpolate field");

    // R11: overflow corner values.
    for (int k = 0; k < FL; k++)
      for (int c = 0; c < LW; c++)
        fld[k][c] = (k % 2 == 0) ? {PW{1'b1}} : ((c % 2 == 0) ? {PW{1'b1}} : '0);
    build_exp(1);
    send_field(0, 1, 1);
    drain("R11 no overflow");
    chk(mean_px(24'hFFFFFF, 24'h000000) == 24'h808080, "R11 bench mean",
        64'(mean_px(24'hFFFFFF, 24'h000000)), 64'h808080);

    // R10: mode flipped after the field start is ignored, both ways.
    fill_random();
    build_exp(1);
    send_field(0, 1, 0);
    drain("R10 mode held interpolate");
    fill_random();
    build_exp(0);
    send_field(0, 0, 1);
    drain("R10 mode held duplicate");

    // Random mix of parity and mode, back to back with stalls.
    for (int f = 0; f < 12; f++) begin
      bit p, m;
      p = 1'($urandom_range(0, 1));
      m = 1'($urandom_range(0, 1));
      fill_random();
      if (!p) build_exp(m);
      send_field(p, m, ~m);
    end
    drain("R6 random fields");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule